// File: doc/BRIEF.md
# Saturating Multiply-Accumulate with Staged Rounding

This block multiplies two signed two's-complement operands and keeps a running sum of the products. The full-width product is never stored. Word length is cut down at three chained points. First the product loses `PROD_DROP` low bits. Next, the sum of that value and the aligned accumulator loses `ACC_DROP` low bits and is stored in an `S`-bit accumulator. Finally the accumulator loses `OUT_DROP` low bits and is narrowed to the `OUT_W`-bit result bus. A two-bit mode input chooses how every one of these cuts is rounded.

When a value does not fit its destination on the sign side, it is clamped to the nearest representable extreme instead of wrapping, and an overflow flag is raised. The flag stays set until the accumulator is cleared. A clear that arrives with a valid operand pair starts a new sum from that pair's product. A clear that arrives alone empties the accumulator. With the defaults (16-bit Q15 operands, `PROD_DROP`=4, `ACC_DROP`=4, `OUT_DROP`=7), the result bus is Q15.

Top module: `mac_sat_round`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, `y_o` becomes 0, `ovf_o` becomes 0 and the accumulator is emptied.
- R2: The result and flag change only at a clock edge where `valid_i` or `clr_i` is high, and they show the effect of that edge's inputs from that edge on (one register stage). With both low, the result, the flag and the accumulator hold.
- R3: The full 2·`DATA_W`-bit signed product of `a_i` and `b_i` is rounded by removing its `PROD_DROP` least significant bits, giving an `S` = 2·`DATA_W`−`PROD_DROP` bit value.
- R4: The accumulator, shifted left by `ACC_DROP` bits, is added to the rounded product. The sum is rounded by removing `ACC_DROP` low bits and is stored as the new `S`-bit accumulator.
- R5: `y_o` is the new accumulator rounded by removing `OUT_DROP` low bits and then narrowed to `OUT_W` bits.
- R6: `mode_i` applies to all three roundings, with removed width d. Code 2'b00 is round to nearest: it adds 2^(d−1) and then truncates toward −∞, so ties go up. Code 2'b01 is floor: it adds 0. Code 2'b10 is ceiling: it adds 2^d−1. Code 2'b11 acts as floor.
- R7: A rounded sum outside the `S`-bit signed range is stored as +(2^(S−1)−1) when the true sum is positive and as −2^(S−1) when it is negative. This also sets `ovf_o`.
- R8: A rounded accumulator outside the `OUT_W`-bit signed range gives `y_o` = 2^(OUT_W−1)−1 or −2^(OUT_W−1), following its sign, and sets `ovf_o`.
- R9: Once set, `ovf_o` stays high through later accumulations until a clear.
- R10: With `valid_i` and `clr_i` both high, the old accumulator is discarded and the rounded product alone is loaded. `ovf_o` then reflects only that transaction's saturation.
- R11: With `clr_i` high and `valid_i` low, the accumulator and `y_o` become 0 and `ovf_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operand pair on `a_i`/`b_i` is to be accumulated |
| clr_i | input | 1 | Restart the sum (load with valid, zero without) |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 floor, 10 ceiling, 11 floor |
| a_i | input | DATA_W | First signed operand |
| b_i | input | DATA_W | Second signed operand |
| y_o | output | OUT_W | Registered signed result |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `rst_ni` is held low at the first clock edge. They also assume that `valid_i`, `clr_i` and `mode_i` are free of X whenever reset is released. The stimulus sets the operands and controls only between rising edges, and it keeps reset asserted for several cycles at the start. The random mix uses all four mode codes, including the spare code. It uses clear both with and without valid, and it pushes operands to their extremes often enough to drive both saturation points. The assertions therefore see every branch of the control without the inputs ever leaving a defined state.

// File: rtl/mac_pkg.sv
// Shared types for the saturating multiply-accumulate.
// Assumes: mode encoding is fixed by the requirement that defines it.
package mac_pkg;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_FLOOR   = 2'b01,
        RND_CEIL    = 2'b10,
        RND_SPARE   = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/mac_mult.sv
// Full-width signed multiplier.
// Assumes: operands are two's complement and the product needs all 2*DATA_W bits.
module mac_mult #(
    parameter int DATA_W = 16,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [PROD_W-1:0] p_o
);

    logic signed [PROD_W-1:0] prod;

    // Signed product sized to the full result width.
    always_comb begin
        prod = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));
    end

    assign p_o = prod;

endmodule

// File: rtl/mac_round_sat.sv
// Drops DROP low bits of a signed value with the selected rounding, then
// clamps the result into OUT_W signed bits and reports any clamp.
// Assumes: IN_W + 1 - DROP >= OUT_W, so the clamp only ever narrows.
module mac_round_sat
    import mac_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int DROP  = 4,
    parameter int OUT_W = 28,
    localparam int EW   = IN_W + 1
) (
    input  logic [IN_W-1:0]  x_i,
    input  logic [1:0]       mode_i,
    output logic [OUT_W-1:0] y_o,
    output logic             sat_o
);

    logic signed [EW-1:0] shifted;
    logic                 fits;

    generate
        if (DROP == 0) begin : g_pass
            logic unused_mode;
            // Nothing to drop: only sign-extend.
            always_comb begin
                shifted     = {x_i[IN_W-1], x_i};
                unused_mode = ^mode_i;
            end
        end else begin : g_round
            logic signed [EW-1:0] ext;
            logic signed [EW-1:0] bias;
            logic signed [EW-1:0] biased;
            // Add the mode's bias, then shift right arithmetically.
            always_comb begin
                ext = {x_i[IN_W-1], x_i};
                case (rnd_mode_e'(mode_i))
                    RND_NEAREST: bias = EW'(1) << (DROP - 1);
                    RND_CEIL:    bias = (EW'(1) << DROP) - EW'(1);
                    default:     bias = '0;
                endcase
                biased  = ext + bias;
                shifted = biased >>> DROP;
            end
        end
    endgenerate

    // In range when every bit above the target sign bit copies it.
    always_comb begin
        fits  = (&shifted[EW-1:OUT_W-1]) | ~(|shifted[EW-1:OUT_W-1]);
        sat_o = ~fits;
        if (fits)
            y_o = shifted[OUT_W-1:0];
        else if (shifted[EW-1])
            y_o = {1'b1, {(OUT_W-1){1'b0}}};
        else
            y_o = {1'b0, {(OUT_W-1){1'b1}}};
    end

endmodule

// File: rtl/mac_sat_round.sv
// Saturating multiply-accumulate with three chained rounding points:
// product, accumulator update and output bus. A clamp at any point sets a
// sticky flag that only a clear removes.
// Assumes: ACC_DROP >= 1 and OUT_DROP keeps S + 1 - OUT_DROP >= OUT_W.
module mac_sat_round #(
    parameter int DATA_W    = 16,
    parameter int PROD_DROP = 4,
    parameter int ACC_DROP  = 4,
    parameter int OUT_DROP  = 7,
    parameter int OUT_W     = 16,
    localparam int PROD_W   = 2 * DATA_W,
    localparam int S        = PROD_W - PROD_DROP,
    localparam int T        = S + ACC_DROP + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic              clr_i,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [OUT_W-1:0]  y_o,
    output logic              ovf_o
);

    logic [PROD_W-1:0] prod;
    logic [S-1:0]      prod_rnd;
    logic              prod_sat;
    logic [S-1:0]      acc_q;
    logic [S-1:0]      acc_base;
    logic [T-1:0]      acc_sum;
    logic [S-1:0]      acc_rnd;
    logic              acc_sat;
    logic [OUT_W-1:0]  y_nxt;
    logic              out_sat;
    logic [OUT_W-1:0]  y_q;
    logic              flag_q;

    mac_mult #(.DATA_W(DATA_W)) u_mult (
        .a_i (a_i),
        .b_i (b_i),
        .p_o (prod)
    );

    mac_round_sat #(.IN_W(PROD_W), .DROP(PROD_DROP), .OUT_W(S)) u_prod_rnd (
        .x_i    (prod),
        .mode_i (mode_i),
        .y_o    (prod_rnd),
        .sat_o  (prod_sat)
    );

    // Align the accumulator onto the product grid and add.
    always_comb begin
        acc_base = clr_i ? '0 : acc_q;
        acc_sum  = {acc_base[S-1], acc_base, {ACC_DROP{1'b0}}}
                 + {{(ACC_DROP + 1){prod_rnd[S-1]}}, prod_rnd};
    end

    mac_round_sat #(.IN_W(T), .DROP(ACC_DROP), .OUT_W(S)) u_acc_rnd (
        .x_i    (acc_sum),
        .mode_i (mode_i),
        .y_o    (acc_rnd),
        .sat_o  (acc_sat)
    );

    mac_round_sat #(.IN_W(S), .DROP(OUT_DROP), .OUT_W(OUT_W)) u_out_rnd (
        .x_i    (acc_rnd),
        .mode_i (mode_i),
        .y_o    (y_nxt),
        .sat_o  (out_sat)
    );

    // State update: accumulate, clear, or hold.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            y_q    <= '0;
            flag_q <= 1'b0;
        end else if (valid_i) begin
            acc_q  <= acc_rnd;
            y_q    <= y_nxt;
            flag_q <= (flag_q & ~clr_i) | prod_sat | acc_sat | out_sat;
        end else if (clr_i) begin
            acc_q  <= '0;
            y_q    <= '0;
            flag_q <= 1'b0;
        end
    end

    assign y_o   = y_q;
    assign ovf_o = flag_q;

endmodule

// File: rtl/mac_sat_round_chk.sv
// Assertion checker for mac_sat_round, attached by bind below.
// Assumes: reset is low at the first clock edge.
module mac_sat_round_chk #(
    parameter int ACC_W = 28,
    parameter int OUT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic             clr_i,
    input logic [OUT_W-1:0] y_i,
    input logic             flag_i,
    input logic [ACC_W-1:0] acc_i,
    input logic             prod_sat_i,
    input logic             acc_sat_i,
    input logic             out_sat_i
);

    localparam logic [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] AMIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] YMAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] YMIN = {1'b1, {(OUT_W-1){1'b0}}};

    p_reset_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (y_i == '0 && !flag_i && acc_i == '0));

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_i && !clr_i) |=> ($stable(y_i) && $stable(flag_i) && $stable(acc_i)));

    p_acc_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && acc_sat_i) |=> (flag_i && (acc_i == AMAX || acc_i == AMIN)));

    p_out_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && out_sat_i) |=> (flag_i && (y_i == YMAX || y_i == YMIN)));

    p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !clr_i) |=> flag_i);

    p_clear_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && clr_i && !prod_sat_i && !acc_sat_i && !out_sat_i) |=> !flag_i);

    p_clear_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !valid_i) |=> (y_i == '0 && !flag_i && acc_i == '0));

endmodule

bind mac_sat_round mac_sat_round_chk #(.ACC_W(S), .OUT_W(OUT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .clr_i      (clr_i),
    .y_i        (y_o),
    .flag_i     (ovf_o),
    .acc_i      (acc_q),
    .prod_sat_i (prod_sat),
    .acc_sat_i  (acc_sat),
    .out_sat_i  (out_sat)
);

// File: tb/test_mac_sat_round.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a staged-rounding model held in bench functions.
module test_mac_sat_round;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int PD = 4;
    localparam int AD = 4;
    localparam int OD = 7;
    localparam int OW = 16;
    localparam int SW = 2 * DW - PD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic          clr = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic [OW-1:0] y;
    logic          ovf;

    int     checks = 0;
    int     fails = 0;
    bit     done = 1'b0;
    longint m_acc = 0;
    longint m_y = 0;
    bit     m_f = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_sat_round #(
        .DATA_W(DW), .PROD_DROP(PD), .ACC_DROP(AD), .OUT_DROP(OD), .OUT_W(OW)
    ) i_mac_sat_round (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr),
        .mode_i(mode), .a_i(a), .b_i(b), .y_o(y), .ovf_o(ovf)
    );

    // Rounding per R6: bias by mode, then arithmetic shift.
    function automatic longint rnd(longint x, int d, logic [1:0] md);
        longint bias;
        if (md == 2'b00)      bias = longint'(1) << (d - 1);
        else if (md == 2'b10) bias = (longint'(1) << d) - 1;
        else                  bias = 0;
        return (x + bias) >>> d;
    endfunction

    // Clamp into w signed bits, reporting the clamp.
    function automatic longint sat(longint v, int w, output bit o);
        longint hi;
        longint lo;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        o = (v > hi) || (v < lo);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic check(string req);
        checks++;
        if (longint'($signed(y)) != m_y || ovf != m_f) begin
            fails++;
            $display("FAIL %s: y=%0d ovf=%0b expected y=%0d ovf=%0b",
                     req, $signed(y), ovf, m_y, m_f);
        end
    endtask

    // Drive one cycle, update the model at the edge, check after it.
    task automatic step(bit v, bit c, int av, int bv, logic [1:0] md, string req);
        bit o1, o2, o3;
        longint base, p1, s, na;
        valid = v; clr = c; a = DW'(av); b = DW'(bv); mode = md;
        @(posedge clk);
        if (v) begin
            base = c ? 0 : m_acc;
            p1 = sat(rnd(longint'($signed(a)) * longint'($signed(b)), PD, md), SW, o1);
            s = base * (longint'(1) << AD) + p1;
            na = sat(rnd(s, AD, md), SW, o2);
            m_y = sat(rnd(na, OD, md), OW, o3);
            m_f = (c ? 1'b0 : m_f) | o1 | o2 | o3;
            m_acc = na;
        end else if (c) begin
            m_acc = 0; m_y = 0; m_f = 1'b0;
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R1");
        rst_n = 1'b1;

        // R10: clear with valid loads 0.5*0.5 -> 8192
        step(1, 1, 16384, 16384, 2'b00, "R10");
        // R2: idle cycles hold while operands move
        step(0, 0, -5, 777, 2'b10, "R2");
        step(0, 0, 32767, -32768, 2'b01, "R2");
        // R4: accumulate up and down
        step(1, 0, 16384, 16384, 2'b00, "R4");
        step(1, 0, -16384, 16384, 2'b00, "R4");
        // R6: mode differences on tiny products
        step(1, 1, 1, 1, 2'b10, "R6");
        step(1, 1, 1, 1, 2'b01, "R6");
        step(1, 1, 1, 1, 2'b00, "R6");
        step(1, 1, -1, 1, 2'b01, "R6");
        step(1, 1, -1, 1, 2'b00, "R6");
        step(1, 1, -1, 1, 2'b10, "R6");
        step(1, 1, -1, 1, 2'b11, "R6");
        // R3: product rounding on mid-size values
        step(1, 1, 12345, -321, 2'b00, "R3");
        step(1, 0, 999, 777, 2'b10, "R3");
        // R8: output clamp from -1 * -1
        step(1, 1, -32768, -32768, 2'b00, "R8");
        // R9: flag survives a small accumulation and an idle cycle
        step(1, 0, 1, 1, 2'b00, "R9");
        step(0, 0, 0, 0, 2'b00, "R9");
        // R7: drive accumulator to positive clamp, then walk down
        for (int i = 0; i < 40; i++) step(1, 0, -32768, -32768, 2'b01, "R7");
        for (int i = 0; i < 33; i++) step(1, 0, -32768, 32767, 2'b01, "R7");
        // R7: negative clamp
        step(1, 1, -32768, 32767, 2'b00, "R7");
        for (int i = 0; i < 40; i++) step(1, 0, -32768, 32767, 2'b00, "R7");
        step(1, 0, 32767, 32767, 2'b00, "R7");
        // R10: clear-load after overflow restarts the flag
        step(1, 1, 16384, 16384, 2'b00, "R10");
        // R11: clear without valid empties everything
        step(1, 1, -32768, -32768, 2'b00, "R11");
        step(0, 1, 123, 456, 2'b00, "R11");

        // Random traffic covering R3 R4 R5 with all controls
        for (int i = 0; i < 600; i++) begin
            int av, bv;
            bit v, c;
            av = int'($signed(16'($urandom())));
            bv = int'($signed(16'($urandom())));
            if ($urandom_range(0, 7) == 0) av = ($urandom_range(0, 1) != 0) ? 32767 : -32768;
            if ($urandom_range(0, 7) == 0) bv = ($urandom_range(0, 1) != 0) ? 32767 : -32768;
            v = ($urandom_range(0, 3) != 0);
            c = ($urandom_range(0, 11) == 0);
            step(v, c, av, bv, 2'($urandom_range(0, 3)), "R3 R4 R5");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule